// File: doc/BRIEF.md
# MSI Doorbell Interrupt Controller

This block turns inbound message-signalled interrupts into per-vector pending state for a host CPU. Each inbound memory write is compared with a programmed 64-bit doorbell address. On a match, the data word of the write is read as a vector index, and the status bit for that vector is set. The bit is set only if that vector is enabled.

Vectors are organised in groups of 32. Each group has three registers: an enable word, a mask word and a write-1-to-clear status word. Software reaches these registers, and the doorbell address, through a simple 32-bit register port. The block drives one interrupt line. That line is high while any group holds a status bit whose mask bit is clear.

The number of groups is a parameter (default 8, giving 256 vectors). Software finds which vectors are pending by reading the status words. It acknowledges a vector by writing a one to that vector's bit.

Top module: `msi_doorbell_ctrl`

## Requirements
- R1: An inbound write takes effect only when its full 64-bit address equals {high word, low word} of the doorbell register pair. Any other address changes no status bit.
- R2: The data of a matching write is the vector number v. It selects group v/32 and bit v mod 32. A data value of 32 × NUM_GROUPS or more is discarded.
- R3: A matching write to a vector whose enable bit is 0 sets no status bit.
- R4: Writing a word to a status register clears exactly the bits written as 1. All other status bits keep their value.
- R5: Enable and mask registers hold the full 32-bit word last written and change only when their own offset is written.
- R6: If a doorbell set and a software clear reach the same status bit in one cycle, the bit ends up set.
- R7: irq_out is high exactly when some group has a status bit set with its mask bit clear. Masking hides a bit from irq_out but does not clear it.
- R8: Register offsets are fixed:
  - doorbell low word at 0x820 and high word at 0x824;
  - for group g, enable at 0x828+12g, mask at 0x82C+12g and status at 0x830+12g.

  reg_rdata shows the addressed word one cycle after reg_rd_en. Any other offset reads as 0, and a write to it changes nothing.
- R9: After reset every register reads 0 and irq_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_wr_valid | input | 1 | Inbound memory write present this cycle |
| in_wr_addr | input | 64 | Address of the inbound write |
| in_wr_data | input | 32 | Data of the inbound write (vector number) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd_en |
| irq_out | output | 1 | Aggregated interrupt to the host |

## Verification
The embedded properties check several rules on every cycle:
- a status bit never rises for a vector that was disabled;
- a status bit falls only when a one was written to it;
- a doorbell set survives a clear to the same bit in the same cycle;
- enable words hold between writes;
- unmapped reads return zero;
- a non-matching inbound write leaves the interrupt line alone.

Some behaviours only the bench scenarios can show. These are that the right group and bit are chosen from a vector number, that out-of-range vectors and high-word mismatches are dropped, and that masking hides a pending bit without losing it.

// File: rtl/msi_db_pkg.sv
package msi_db_pkg;

  localparam int unsigned DATA_W      = 32;
  localparam int unsigned REG_AW      = 12;
  localparam int unsigned VEC_PER_GRP = 32;
  localparam int unsigned GRP_STRIDE  = 12;

  // Offsets that software decodes
  localparam logic [REG_AW-1:0] OFS_DB_LO    = 12'h820;
  localparam logic [REG_AW-1:0] OFS_DB_HI    = 12'h824;
  localparam logic [REG_AW-1:0] OFS_GRP_BASE = 12'h828;

  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [REG_AW-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } reg_req_t;

endpackage

// File: rtl/msi_db_match.sv
module msi_db_match
  import msi_db_pkg::*;
#(
  parameter int unsigned NUM_VEC = 256,
  parameter int unsigned GRP_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  reg_req_t          req,
  input  logic              in_wr_valid,
  input  logic [63:0]       in_wr_addr,
  input  logic [DATA_W-1:0] in_wr_data,
  output logic              set_valid,
  output logic [GRP_W-1:0]  set_grp,
  output logic [4:0]        set_bit,
  output logic [63:0]       db_addr,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic              lo_ld, hi_ld;
  logic              hit_lo, hit_hi;
  logic              addr_eq, vec_ok;

  // Register decode
  always_comb begin
    hit_lo = (req.addr == OFS_DB_LO);
    hit_hi = (req.addr == OFS_DB_HI);
    lo_ld  = req.wr && hit_lo;
    hi_ld  = req.wr && hit_hi;
    lo_d   = req.wdata;
    hi_d   = req.wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_ld) lo_q <= lo_d;
      if (hi_ld) hi_q <= hi_d;
    end
  end

  // Doorbell match and vector split
  always_comb begin
    db_addr   = {hi_q, lo_q};
    addr_eq   = (in_wr_addr == db_addr);
    vec_ok    = (in_wr_data < DATA_W'(NUM_VEC));
    set_valid = in_wr_valid && addr_eq && vec_ok;
    set_grp   = GRP_W'(in_wr_data >> 5);
    set_bit   = in_wr_data[4:0];
  end

  // Read-back
  always_comb begin
    rd_hit  = hit_lo || hit_hi;
    rd_word = '0;
    if (hit_lo) rd_word = lo_q;
    if (hit_hi) rd_word = hi_q;
  end

endmodule

// File: rtl/msi_db_bank.sv
module msi_db_bank
  import msi_db_pkg::*;
#(
  parameter int unsigned GRP_IDX = 0,
  parameter int unsigned GRP_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  reg_req_t          req,
  input  logic              set_valid,
  input  logic [GRP_W-1:0]  set_grp,
  input  logic [4:0]        set_bit,
  output logic              pend,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_word
);

  localparam logic [REG_AW-1:0] EN_OFS = REG_AW'(OFS_GRP_BASE + GRP_IDX * GRP_STRIDE);
  localparam logic [REG_AW-1:0] MK_OFS = REG_AW'(EN_OFS + 4);
  localparam logic [REG_AW-1:0] ST_OFS = REG_AW'(EN_OFS + 8);

  logic [DATA_W-1:0] en_q, mk_q, st_q;
  logic [DATA_W-1:0] en_d, mk_d, st_d;
  logic              en_ld, mk_ld, st_ld;
  logic              hit_en, hit_mk, hit_st;
  logic              set_this;
  logic [DATA_W-1:0] raw_set, gated_set, clr;

  // Decode and next state
  always_comb begin
    hit_en    = (req.addr == EN_OFS);
    hit_mk    = (req.addr == MK_OFS);
    hit_st    = (req.addr == ST_OFS);
    set_this  = set_valid && (set_grp == GRP_W'(GRP_IDX));
    raw_set   = set_this ? (DATA_W'(1) << set_bit) : '0;
    gated_set = raw_set & en_q;
    clr       = (req.wr && hit_st) ? req.wdata : '0;
    en_ld     = req.wr && hit_en;
    mk_ld     = req.wr && hit_mk;
    en_d      = req.wdata;
    mk_d      = req.wdata;
    st_d      = (st_q & ~clr) | gated_set;  // set wins
    st_ld     = (|clr) || (|gated_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      mk_q <= '0;
      st_q <= '0;
    end else begin
      if (en_ld) en_q <= en_d;
      if (mk_ld) mk_q <= mk_d;
      if (st_ld) st_q <= st_d;
    end
  end

  always_comb begin
    pend    = |(st_q & ~mk_q);
    rd_hit  = hit_en || hit_mk || hit_st;
    rd_word = '0;
    if (hit_en) rd_word = en_q;
    if (hit_mk) rd_word = mk_q;
    if (hit_st) rd_word = st_q;
  end

  // R3: a newly set status bit was enabled the cycle before
  p_set_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q & ~$past(st_q) & ~$past(en_q)) == '0));

  // R4: a status bit only falls where a one was written
  p_w1c_only_written_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((~st_q & $past(st_q) & ~$past(clr)) == '0));

  // R6: a doorbell set survives a simultaneous clear
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|gated_set) |=> ((st_q & $past(gated_set)) == $past(gated_set)));

  // R5: enable word holds between its own writes
  p_enable_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_ld) |=> $stable(en_q));

endmodule

// File: rtl/msi_doorbell_ctrl.sv
module msi_doorbell_ctrl
  import msi_db_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_wr_valid,
  input  logic [63:0] in_wr_addr,
  input  logic [31:0] in_wr_data,
  input  logic        reg_wr_en,
  input  logic        reg_rd_en,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_out
);

  localparam int unsigned NUM_VEC = NUM_GROUPS * VEC_PER_GRP;
  localparam int unsigned GRP_W   = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  reg_req_t          req;
  logic              set_valid;
  logic [GRP_W-1:0]  set_grp;
  logic [4:0]        set_bit;
  logic [63:0]       db_addr;
  logic              m_hit;
  logic [DATA_W-1:0] m_word;
  logic [NUM_GROUPS-1:0] b_pend, b_hit;
  logic [DATA_W-1:0] b_word [NUM_GROUPS];
  logic [DATA_W-1:0] mux_word, rdata_q, rdata_d;
  logic              any_hit, rdata_ld;

  always_comb begin
    req.wr    = reg_wr_en;
    req.rd    = reg_rd_en;
    req.addr  = reg_addr;
    req.wdata = reg_wdata;
  end

  msi_db_match #(.NUM_VEC(NUM_VEC), .GRP_W(GRP_W)) u_match (
    .clk(clk), .rst_n(rst_n), .req(req),
    .in_wr_valid(in_wr_valid), .in_wr_addr(in_wr_addr), .in_wr_data(in_wr_data),
    .set_valid(set_valid), .set_grp(set_grp), .set_bit(set_bit),
    .db_addr(db_addr), .rd_hit(m_hit), .rd_word(m_word)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
    msi_db_bank #(.GRP_IDX(g), .GRP_W(GRP_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .req(req),
      .set_valid(set_valid), .set_grp(set_grp), .set_bit(set_bit),
      .pend(b_pend[g]), .rd_hit(b_hit[g]), .rd_word(b_word[g])
    );
  end

  // Read mux: unmapped offsets fall through to zero
  always_comb begin
    mux_word = m_word;
    for (int g = 0; g < NUM_GROUPS; g++) mux_word = mux_word | b_word[g];
    any_hit  = m_hit || (|b_hit);
    rdata_ld = reg_rd_en;
    rdata_d  = mux_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_ld) rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;
  assign irq_out   = |b_pend;

  // R8: an unmapped read returns zero
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && !any_hit) |=> (reg_rdata == '0));

  // R1: a non-matching inbound write alone cannot move the interrupt line
  p_mismatch_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wr_valid && (in_wr_addr != db_addr) && !reg_wr_en) |=> $stable(irq_out));

endmodule

// File: tb/msi_doorbell_ctrl_test.sv
module msi_doorbell_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_wr_valid;
  logic [63:0] in_wr_addr;
  logic [31:0] in_wr_data;
  logic        reg_wr_en, reg_rd_en;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  localparam logic [63:0] DB = 64'h0000_0000_FEE0_1000;

  always #4 clk = ~clk;  // 125 MHz

  msi_doorbell_ctrl #(.NUM_GROUPS(8)) uut (
    .clk(clk), .rst_n(rst_n), .in_wr_valid(in_wr_valid), .in_wr_addr(in_wr_addr),
    .in_wr_data(in_wr_data), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  function automatic logic [11:0] en_ofs(int g); return 12'(12'h828 + 12 * g); endfunction
  function automatic logic [11:0] mk_ofs(int g); return 12'(12'h82C + 12 * g); endfunction
  function automatic logic [11:0] st_ofs(int g); return 12'(12'h830 + 12 * g); endfunction

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic bell(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk);
    in_wr_valid = 1'b1; in_wr_addr = a; in_wr_data = d;
    @(negedge clk);
    in_wr_valid = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    n_cmp++;
    if (irq_out !== e) begin
      n_bad++;
      $display("FAIL %s irq_out actual=%0b expected=%0b", t, irq_out, e);
    end
  endtask

  // Monitor: pops one expected word per issued read
  initial begin
    forever begin
      logic was;
      @(posedge clk);
      was = reg_rd_en;
      @(negedge clk);
      if (was && exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (reg_rdata !== e) begin
          n_bad++;
          $display("FAIL %s rdata actual=%08h expected=%08h", t, reg_rdata, e);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_wr_valid = 0; in_wr_addr = '0; in_wr_data = '0;
    reg_wr_en = 0; reg_rd_en = 0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    chk_irq(1'b0, "R9 irq after reset");
    rd(st_ofs(0), 32'h0, "R9 status0 reset");
    rd(12'h820, 32'h0, "R9 db lo reset");
    rd(en_ofs(7), 32'h0, "R9 enable7 reset");

    // R8 program doorbell address and read back
    wr(12'h820, DB[31:0]);
    wr(12'h824, DB[63:32]);
    rd(12'h820, 32'hFEE0_1000, "R8 db lo readback");
    rd(12'h824, 32'h0, "R8 db hi readback");

    // R5 enables: vectors 0,2 in group 0; vector 127 in group 3
    wr(en_ofs(0), 32'h0000_0005);
    wr(en_ofs(3), 32'h8000_0000);
    rd(en_ofs(0), 32'h0000_0005, "R5 enable0 readback");

    // R1/R7 matching doorbell for vector 2
    bell(DB, 32'd2);
    rd(st_ofs(0), 32'h0000_0004, "R1 status0 after vec2");
    chk_irq(1'b1, "R7 irq pending vec2");

    // R3 disabled vector 1
    bell(DB, 32'd1);
    rd(st_ofs(0), 32'h0000_0004, "R3 disabled vec1 discarded");

    // R1 wrong low address, wrong high word
    bell(DB + 64'h4, 32'd0);
    bell(DB | 64'h1_0000_0000, 32'd0);
    rd(st_ofs(0), 32'h0000_0004, "R1 mismatched addresses ignored");

    // R2 vector 127 -> group 3 bit 31; vector 256 out of range
    bell(DB, 32'd127);
    rd(st_ofs(3), 32'h8000_0000, "R2 vec127 in group3");
    bell(DB, 32'd256);
    rd(st_ofs(0), 32'h0000_0004, "R2 vec256 discarded");

    // R7 masking
    wr(mk_ofs(0), 32'h0000_0004);
    chk_irq(1'b1, "R7 group3 still pending");
    wr(st_ofs(3), 32'h8000_0000);
    chk_irq(1'b0, "R7 all pending masked");
    rd(st_ofs(0), 32'h0000_0004, "R7 mask keeps status");
    rd(st_ofs(3), 32'h0, "R4 group3 cleared");

    // R4 W1C leaves other bits
    bell(DB, 32'd0);
    rd(st_ofs(0), 32'h0000_0005, "R4 status0 two bits");
    chk_irq(1'b1, "R7 unmasked vec0 pending");
    wr(st_ofs(0), 32'h0000_0001);
    rd(st_ofs(0), 32'h0000_0004, "R4 only bit0 cleared");
    chk_irq(1'b0, "R7 irq low after clear");

    // R6 set and clear in the same cycle
    @(negedge clk);
    in_wr_valid = 1'b1; in_wr_addr = DB; in_wr_data = 32'd2;
    reg_wr_en = 1'b1; reg_addr = st_ofs(0); reg_wdata = 32'h0000_0004;
    @(negedge clk);
    in_wr_valid = 1'b0; reg_wr_en = 1'b0;
    rd(st_ofs(0), 32'h0000_0004, "R6 set wins over clear");
    wr(st_ofs(0), 32'h0000_0004);
    rd(st_ofs(0), 32'h0, "R4 clear after race");

    // R5 full-word enable/mask on the last group
    wr(en_ofs(7), 32'h1234_5678);
    wr(mk_ofs(7), 32'h8765_4321);
    rd(en_ofs(7), 32'h1234_5678, "R5 enable7 word");
    rd(mk_ofs(7), 32'h8765_4321, "R5 mask7 word");
    rd(en_ofs(0), 32'h0000_0005, "R5 enable0 undisturbed");

    // R8 unmapped offsets
    wr(12'h888, 32'hFFFF_FFFF);
    rd(12'h888, 32'h0, "R8 beyond last group");
    rd(12'h000, 32'h0, "R8 low offset");
    rd(12'h82A, 32'h0, "R8 misaligned offset");

    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule